// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block keeps the coherence state of every line of one cache that shares a snooping bus with other caches. Each line sits in one of four states: invalid, valid (clean and possibly shared), reserved (written exactly once, still clean, the only copy) or dirty (written again, the only copy, newer than memory). The first store to a shared line is written through to memory while the other copies are invalidated. Later stores stay in the cache.

The cache pipeline hands the block one request at a time: a read, a write or a replacement of a line, selected by a line index. Whether the request hits is derived from the stored state. Requests that need the bus raise a bus request carrying a command and the line index, and they wait for a one-cycle acknowledge. Transactions issued by other caches arrive on a snoop port. They can downgrade or invalidate local lines, and they raise an intervention flag whenever this cache must supply dirty data in place of memory.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high and `bus_req`, `rsp_valid` and `snp_intervene` are low.
- R2: A read (`req_op` 0) to a line that is not invalid raises `rsp_valid` in the cycle after acceptance, issues no bus command and leaves the line state unchanged.
- R3: A read to an invalid line issues bus command 1 (read). After the acknowledge the line becomes valid and `rsp_valid` rises in the following cycle.
- R4: A write (`req_op` 1) to a valid line issues bus command 3 (invalidate) and then command 4 (memory write) as two acknowledged transactions, and the line becomes reserved.
- R5: A write to a reserved or dirty line uses no bus, responds in the cycle after acceptance and leaves the line dirty.
- R6: A write to an invalid line issues bus command 2 (read-exclusive), and the line becomes dirty.
- R7: A replacement (`req_op` 2) of a dirty line issues bus command 5 (write-back). A replacement of a valid, reserved or invalid line uses no bus. In every case the line ends invalid.
- R8: A snooped invalidate (command 3) or read-exclusive (command 2) makes the addressed local line invalid, whatever its state.
- R9: A snooped read (command 1) turns a reserved or dirty line into valid and leaves a valid or invalid line unchanged.
- R10: `snp_intervene` is high in the same cycle as a snooped read or read-exclusive that addresses a dirty line, and low for every other snoop.
- R11: From acceptance of a request that needs the bus until its final acknowledge, `req_ready` stays low, so at most one request is outstanding. The bus command and index stay stable while `bus_req` waits for the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | 0 read, 1 write, 2 replace |
| req_idx | input | IDX_W | Line index of the local request |
| req_ready | output | 1 | Controller idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle pulse when a request completes |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 3 | 1 read, 2 read-exclusive, 3 invalidate, 4 memory write, 5 write-back |
| bus_idx | output | IDX_W | Line index of the bus transaction |
| bus_ack | input | 1 | Bus transaction completed this cycle |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_idx | input | IDX_W | Snooped line index |
| snp_intervene | output | 1 | This cache supplies dirty data; memory must stay silent |

## Verification
A request that needs no bus produces `rsp_valid` one cycle after the edge that accepts it. A request that needs the bus shows `bus_req` one cycle after acceptance, and its response follows one cycle after the edge that samples the final acknowledge. A two-step write hit shows its memory-write command in the cycle after the invalidate is acknowledged. `snp_intervene` is combinational and is due in the same cycle as the snoop. The driver pushes the expected bus commands and responses in order, and a monitor samples on falling edges, which lie half a cycle past the register updates. The monitor pops one item per command or response, with an acknowledge delay that varies between runs of the sequence. Snoop results are checked 1 ns after the snoop is driven. Every effect of a snoop on a line's state is then seen through the bus commands of the next local request to that line.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_RES = 2'd2,
    LS_DRT = 2'd3
  } line_st_t;

  typedef enum logic [2:0] {
    BC_NONE  = 3'd0,
    BC_READ  = 3'd1,
    BC_READX = 3'd2,
    BC_INV   = 3'd3,
    BC_MEMWR = 3'd4,
    BC_WB    = 3'd5
  } bus_cmd_t;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RPL = 2'd2,
    OP_RSV = 2'd3
  } lop_t;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_BUS  = 1'b1
  } ctl_st_t;
endpackage

// File: rtl/wo_line_table.sv
module wo_line_table
  import wo_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output line_st_t         lk_st,
  input  logic [IDX_W-1:0] sn_idx,
  output line_st_t         sn_st,
  input  logic             la_en,
  input  logic [IDX_W-1:0] la_idx,
  input  line_st_t         la_st,
  input  logic             sa_en,
  input  logic [IDX_W-1:0] sa_idx,
  input  line_st_t         sa_st
);
  localparam int NLINES = 1 << IDX_W;
  localparam int SW     = $bits(line_st_t);

  logic [NLINES*SW-1:0] flat;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic     hit_l, hit_s, ld;
    line_st_t nxt, q;

    always_comb begin
      hit_l = la_en && (la_idx == IDX_W'(g));
      hit_s = sa_en && (sa_idx == IDX_W'(g));
      ld    = hit_l || hit_s;
      nxt   = hit_l ? la_st : sa_st;  // local completion wins a same-line tie
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= LS_INV;
      else if (ld) q <= nxt;
    end

    assign flat[g*SW +: SW] = q;
  end

  assign lk_st = line_st_t'(flat[lk_idx*SW +: SW]);
  assign sn_st = line_st_t'(flat[sn_idx*SW +: SW]);
endmodule

// File: rtl/wo_snoop_resp.sv
module wo_snoop_resp
  import wo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_valid,
  input  logic [2:0] snp_cmd,
  input  line_st_t cur_st,
  output logic     upd_en,
  output line_st_t upd_st,
  output logic     intervene
);
  always_comb begin
    upd_en    = 1'b0;
    upd_st    = cur_st;
    intervene = 1'b0;
    if (snp_valid) begin
      case (bus_cmd_t'(snp_cmd))
        BC_READ: begin
          intervene = (cur_st == LS_DRT);
          if (cur_st == LS_RES || cur_st == LS_DRT) begin
            upd_en = 1'b1;
            upd_st = LS_VAL;
          end
        end
        BC_READX, BC_INV: begin
          intervene = (cur_st == LS_DRT) && (bus_cmd_t'(snp_cmd) == BC_READX);
          if (cur_st != LS_INV) begin
            upd_en = 1'b1;
            upd_st = LS_INV;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: supplying dirty data always leaves this cache without a dirty copy
  p_intervene_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    intervene |-> upd_en && (upd_st != LS_DRT));

  // R9: a snooped read never invalidates a line
  p_read_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_cmd == 3'd1) && upd_en |-> upd_st == LS_VAL);
endmodule

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl
  import wo_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             bus_req,
  output logic [2:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_ack,
  input  logic             snp_valid,
  input  logic [2:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_intervene
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  line_st_t lk_st, sn_st, la_st, sa_st;
  logic     la_en, sa_en;
  logic [IDX_W-1:0] la_idx;

  wo_line_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n_i),
    .lk_idx(req_idx), .lk_st(lk_st),
    .sn_idx(snp_idx), .sn_st(sn_st),
    .la_en(la_en), .la_idx(la_idx), .la_st(la_st),
    .sa_en(sa_en), .sa_idx(snp_idx), .sa_st(sa_st)
  );

  wo_snoop_resp u_snoop (
    .clk(clk), .rst_n(rst_n_i),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .cur_st(sn_st),
    .upd_en(sa_en), .upd_st(sa_st), .intervene(snp_intervene)
  );

  ctl_st_t          st_q, st_d;
  bus_cmd_t         cmd_q, cmd_d, pl_cmd;
  logic [IDX_W-1:0] idx_q, idx_d;
  line_st_t         fin_q, fin_d, pl_fin, loc_st;
  logic             more_q, more_d, pl_more, need_bus;
  logic             rsp_q, rsp_d, ld;

  // decode of the local request against the current line state
  always_comb begin
    need_bus = 1'b0;
    pl_cmd   = BC_NONE;
    pl_fin   = lk_st;
    pl_more  = 1'b0;
    loc_st   = lk_st;
    case (lop_t'(req_op))
      OP_WR: begin
        case (lk_st)
          LS_INV: begin need_bus = 1'b1; pl_cmd = BC_READX; pl_fin = LS_DRT; end
          LS_VAL: begin need_bus = 1'b1; pl_cmd = BC_INV; pl_fin = LS_RES; pl_more = 1'b1; end
          default: loc_st = LS_DRT;
        endcase
      end
      OP_RPL: begin
        if (lk_st == LS_DRT) begin
          need_bus = 1'b1; pl_cmd = BC_WB; pl_fin = LS_INV;
        end else begin
          loc_st = LS_INV;
        end
      end
      default: begin
        if (lk_st == LS_INV) begin
          need_bus = 1'b1; pl_cmd = BC_READ; pl_fin = LS_VAL;
        end
      end
    endcase
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    idx_d  = idx_q;
    fin_d  = fin_q;
    more_d = more_q;
    rsp_d  = 1'b0;
    ld     = 1'b0;
    la_en  = 1'b0;
    la_idx = req_idx;
    la_st  = loc_st;
    case (st_q)
      CS_IDLE: begin
        if (req_valid) begin
          if (need_bus) begin
            ld     = 1'b1;
            st_d   = CS_BUS;
            cmd_d  = pl_cmd;
            idx_d  = req_idx;
            fin_d  = pl_fin;
            more_d = pl_more;
          end else begin
            rsp_d = 1'b1;
            la_en = 1'b1;
          end
        end
      end
      default: begin
        if (bus_ack) begin
          ld = 1'b1;
          if (more_q) begin
            cmd_d  = BC_MEMWR;  // write-through half of the first store
            more_d = 1'b0;
          end else begin
            st_d   = CS_IDLE;
            rsp_d  = 1'b1;
            la_en  = 1'b1;
            la_idx = idx_q;
            la_st  = fin_q;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q   <= CS_IDLE;
      cmd_q  <= BC_NONE;
      idx_q  <= '0;
      fin_q  <= LS_INV;
      more_q <= 1'b0;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= rsp_d;
      if (ld) begin
        st_q   <= st_d;
        cmd_q  <= cmd_d;
        idx_q  <= idx_d;
        fin_q  <= fin_d;
        more_q <= more_d;
      end
    end
  end

  assign req_ready = (st_q == CS_IDLE);
  assign bus_req   = (st_q == CS_BUS);
  assign bus_cmd   = cmd_q;
  assign bus_idx   = idx_q;
  assign rsp_valid = rsp_q;

  // R11: a waiting bus transaction keeps command and index
  p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_req && !bus_ack |=> bus_req && $stable(bus_cmd) && $stable(bus_idx));

  // R11: no new request is taken while the bus is in use
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_req |-> !req_ready);

  // R2: every response follows an acceptance or a final acknowledge
  p_rsp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> $past(req_valid && req_ready) || $past(bus_req && bus_ack));

  // R4: the memory write only ever continues a running bus sequence
  p_memwr_seq_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_req && (bus_cmd == 3'd4) |-> $past(bus_req));
endmodule

// File: tb/wo_coherence_ctrl_test.sv
module wo_coherence_ctrl_test;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, rsp_valid;
  logic [1:0]    req_op;
  logic [IW-1:0] req_idx, bus_idx, snp_idx;
  logic          bus_req, bus_ack, snp_valid, snp_intervene;
  logic [2:0]    bus_cmd, snp_cmd;

  wo_coherence_ctrl #(.IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx), .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
    .snp_intervene(snp_intervene)
  );

  typedef struct {
    bit            is_bus;
    logic [2:0]    cmd;
    logic [IW-1:0] idx;
    string         tag;
  } exp_t;

  exp_t       expq[$];
  logic [1:0] mdl [8];   // 0 invalid, 1 valid, 2 reserved, 3 dirty
  int checks = 0, errors = 0;
  int ack_dly = 0, dly_cnt = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic void push(input bit b, input logic [2:0] c,
                               input int i, input string t);
    exp_t e;
    e.is_bus = b; e.cmd = c; e.idx = IW'(i); e.tag = t;
    expq.push_back(e);
  endfunction

  // monitor: acknowledges bus requests and compares against the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !finished) begin
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        check(!req_ready, "R11", "ready while busy", int'(req_ready), 0);
        if (dly_cnt < ack_dly) dly_cnt++;
        else begin
          dly_cnt = 0;
          if (expq.size() == 0) check(1'b0, "R11", "unexpected bus cmd", int'(bus_cmd), 0);
          else begin
            e = expq.pop_front();
            check(e.is_bus && e.cmd == bus_cmd && e.idx == bus_idx, e.tag, "bus cmd",
                  int'(bus_cmd), e.is_bus ? int'(e.cmd) : 0);
          end
          bus_ack = 1'b1;
        end
      end
      if (rsp_valid) begin
        if (expq.size() == 0) check(1'b0, "R11", "unexpected response", 1, 0);
        else begin
          e = expq.pop_front();
          check(!e.is_bus, e.tag, "response before bus cmd", 0, int'(e.cmd));
        end
      end
    end
  end

  task automatic do_req(input logic [1:0] op, input int idx, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    case (op)
      2'd1: begin
        if (mdl[idx] == 2'd1) begin
          push(1, 3'd3, idx, tag); push(1, 3'd4, idx, tag); mdl[idx] = 2'd2;
        end else if (mdl[idx] == 2'd0) begin
          push(1, 3'd2, idx, tag); mdl[idx] = 2'd3;
        end else mdl[idx] = 2'd3;
      end
      2'd2: begin
        if (mdl[idx] == 2'd3) push(1, 3'd5, idx, tag);
        mdl[idx] = 2'd0;
      end
      default: begin
        if (mdl[idx] == 2'd0) begin push(1, 3'd1, idx, tag); mdl[idx] = 2'd1; end
      end
    endcase
    push(0, 3'd0, idx, tag);
    req_op = op; req_idx = IW'(idx); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic do_snp(input logic [2:0] c, input int idx, input string tag);
    bit exp_iv;
    @(negedge clk);
    snp_cmd = c; snp_idx = IW'(idx); snp_valid = 1'b1;
    #1;
    exp_iv = (c == 3'd1 || c == 3'd2) && mdl[idx] == 2'd3;
    check(snp_intervene == exp_iv, tag, "intervene", int'(snp_intervene), int'(exp_iv));
    if (c == 3'd1 && mdl[idx] >= 2'd2) mdl[idx] = 2'd1;
    if (c == 3'd2 || c == 3'd3) mdl[idx] = 2'd0;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic run_seq();
    do_req(2'd0, 0, "R3");           // read miss
    do_req(2'd0, 0, "R2");           // read hit
    do_req(2'd1, 0, "R4");           // first write: invalidate + write-through
    do_req(2'd1, 0, "R5");           // reserved -> dirty
    do_req(2'd1, 0, "R5");           // dirty stays dirty
    do_req(2'd0, 0, "R2");           // read hit on dirty, no bus
    do_req(2'd2, 0, "R7");           // dirty replace: write-back
    do_req(2'd0, 0, "R7");           // line now invalid
    do_req(2'd1, 1, "R6");           // write miss
    do_req(2'd2, 2, "R7");           // replace invalid line
    do_req(2'd2, 1, "R7");           // replace dirty
    do_req(2'd0, 3, "R3");
    do_snp(3'd1, 3, "R10");          // read on valid: no intervention
    do_req(2'd1, 3, "R9");           // still valid -> two-step write
    do_snp(3'd1, 3, "R9");           // reserved -> valid
    do_req(2'd1, 3, "R9");
    do_req(2'd1, 3, "R5");           // dirty
    do_snp(3'd1, 3, "R10");          // dirty: intervene, -> valid
    do_req(2'd1, 3, "R9");
    do_req(2'd1, 4, "R6");
    do_snp(3'd2, 4, "R8");           // read-exclusive on dirty: intervene, -> invalid
    do_req(2'd0, 4, "R8");
    do_snp(3'd3, 4, "R8");           // invalidate on valid
    do_req(2'd1, 4, "R8");
    do_snp(3'd3, 4, "R10");          // invalidate on dirty: no intervention
    do_req(2'd0, 4, "R8");
    do_req(2'd1, 7, "R6");           // highest index
    do_req(2'd2, 3, "R7");           // replace valid/reserved line
    do_req(2'd0, 3, "R7");
    do_snp(3'd1, 5, "R10");          // snoop on invalid line
    do_req(2'd0, 5, "R9");
    do_req(2'd2, 7, "R7");
    for (int i = 0; i < 8; i++) do_req(2'd2, i, "R7");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_idx = '0;
    bus_ack = 1'b0; snp_valid = 1'b0; snp_cmd = '0; snp_idx = '0;
    for (int i = 0; i < 8; i++) mdl[i] = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    check(bus_req == 1'b0, "R1", "bus_req", int'(bus_req), 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    check(snp_intervene == 1'b0, "R1", "snp_intervene", int'(snp_intervene), 0);
    for (int i = 0; i < 8; i++) do_req(2'd0, i, "R1");  // all lines miss after reset
    for (int i = 0; i < 8; i++) do_req(2'd2, i, "R7");
    ack_dly = 0;
    run_seq();
    ack_dly = 2;
    run_seq();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "R11", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule